// File: doc/BRIEF.md
# Two-Station Half-Duplex MII Link Emulator

This block sits between two media access controllers that are wired to each other over a media independent interface (MII) in half-duplex mode, with no transceiver chip in between. It stands in for the transceiver's job. It supplies carrier sense and collision detect to both stations. It forwards the transmit nibbles of one station to the receive pins of the other. Both stations and the block run on one shared transmit clock. That clock runs at 2.5 MHz for 10 Mb/s or at 25 MHz for 100 Mb/s, and one nibble moves per clock.

Two rules are enforced that a simple cross-connect would break. First, a station never sees receive-valid while it is itself transmitting, because half-duplex MACs have no loopback path. Second, the collision indication is held back until the header of the frame has fully passed. The header is the preamble, start delimiter, both addresses and the type field: 22 bytes, or 44 nibble clocks. The block is meant for a point-to-point link only. Joining more stations would need an arbiter for carrier and collision.

Each station has a saturating nibble counter that restarts whenever its transmit enable drops. When the two transmissions overlap, the link is locked: receive-valid stays low on both sides until both transmitters are idle. Collision is raised on both sides once the station that started first has sent 44 nibbles, and it is held until both stations go idle.

Top module: `mii_hdx_link`

## Requirements
- R1: While reset is applied, and until the first clock edge after reset has been synchronised, every output is 0.
- R2: `a_crs` and `b_crs` are both equal to the OR of `a_tx_en` and `b_tx_en` sampled at the previous clock edge.
- R3: While exactly one station transmits and no overlap has happened since the link was last idle, the other station's `rx_dv` and `rxd` equal the sender's `tx_en` and `txd` from the previous clock edge.
- R4: A station's `rx_dv` is never 1 in a cycle in which that station's own `tx_en` is 1. This holds combinationally, in the same cycle.
- R5: When the two transmissions overlap, `a_col` and `b_col` rise together on the clock edge after the earlier starter's 44th nibble. That earlier starter first sees collision after 45 edges with its `tx_en` high, and never sooner.
- R6: Once raised, collision stays at 1 on both sides until an edge at which both `tx_en` inputs are sampled low. It then reads 0 after that edge.
- R7: After any overlap, `rx_dv` to both stations stays 0 until both `tx_en` inputs have been sampled low together, even when the overlap ended before 44 nibbles and no collision was raised.
- R8: `rxd` is 4'h0 whenever the matching `rx_dv` is 0.
- R9: If the second station starts after the first has already sent 44 nibbles, collision rises on the first clock edge at which both `tx_en` inputs are sampled high.
- R10: A station's nibble count restarts when its `tx_en` is sampled low, so a new frame after a gap needs a fresh 44 nibbles before collision can be raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared MII transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_tx_en | input | 1 | Station A transmit enable |
| a_txd | input | 4 | Station A transmit nibble |
| a_rx_dv | output | 1 | Receive valid toward station A |
| a_rxd | output | 4 | Receive nibble toward station A |
| a_crs | output | 1 | Carrier sense toward station A |
| a_col | output | 1 | Collision toward station A |
| b_tx_en | input | 1 | Station B transmit enable |
| b_txd | input | 4 | Station B transmit nibble |
| b_rx_dv | output | 1 | Receive valid toward station B |
| b_rxd | output | 4 | Receive nibble toward station B |
| b_crs | output | 1 | Carrier sense toward station B |
| b_col | output | 1 | Collision toward station B |

## Verification
The assertions assume that both stations change `tx_en` and `txd` only between clock edges, synchronous to the shared clock. They also assume that both stations are idle when reset is released, so the reset synchroniser's extra cycles hide no transmission. The bench drives every input one time unit after a rising edge and holds both stations idle across reset and between scenarios. Each scenario starts from an idle, unlocked link, so the nibble counts the bench expects begin from zero.

// File: rtl/mii_link_pkg.sv
package mii_link_pkg;
  // Default nibble width of the MII data path
  localparam int unsigned NIB_W_DEF = 4;
  // Nibble clocks covering preamble, start delimiter, addresses and type
  localparam int unsigned HDR_NIB_DEF = 44;
  // Station indices used by the per-station generate loops
  localparam int unsigned ST_A = 0;
  localparam int unsigned ST_B = 1;
  localparam int unsigned N_ST = 2;
endpackage

// File: rtl/mii_rst_sync.sv
module mii_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mii_hdr_counter.sv
module mii_hdr_counter #(
  parameter int unsigned HDR_NIB = 44,
  localparam int unsigned CNT_W  = $clog2(HDR_NIB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  output logic             hdr_done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // count advances only while transmitting and below the header length
  always_comb begin
    cnt_en = tx_en && (cnt_q != CNT_W'(HDR_NIB));
    if (!tx_en)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hdr_done = (cnt_q == CNT_W'(HDR_NIB));
endmodule

// File: rtl/mii_hdx_arbiter.sv
module mii_hdx_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tx_en,
  input  logic [1:0] hdr_done,
  output logic       crs,
  output logic       col,
  output logic       lock
);
  logic crs_d, col_d, lock_d;
  logic any_tx, both_tx;

  always_comb begin
    any_tx  = |tx_en;
    both_tx = &tx_en;
    crs_d   = any_tx;
    // overlap locks the link until both stations are idle again
    lock_d  = both_tx || (lock && any_tx);
    // collision waits for the earlier starter to finish its header
    col_d   = (both_tx && (|hdr_done)) || (col && any_tx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs  <= 1'b0;
      col  <= 1'b0;
      lock <= 1'b0;
    end else begin
      crs  <= crs_d;
      col  <= col_d;
      lock <= lock_d;
    end
  end
endmodule

// File: rtl/mii_rx_steer.sv
module mii_rx_steer #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic [NIB_W-1:0] src_txd,
  input  logic             own_en,
  input  logic             lock,
  output logic             rx_dv,
  output logic [NIB_W-1:0] rxd
);
  logic             dv_q, dv_d;
  logic [NIB_W-1:0] nib_q, nib_d;

  always_comb begin
    dv_d  = src_en && !own_en && !lock;
    nib_d = dv_d ? src_txd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      nib_q <= '0;
    end else begin
      dv_q  <= dv_d;
      nib_q <= nib_d;
    end
  end

  // same-cycle gate: a station that starts talking stops receiving at once
  assign rx_dv = dv_q && !own_en;
  assign rxd   = rx_dv ? nib_q : '0;
endmodule

// File: rtl/mii_hdx_link.sv
module mii_hdx_link
  import mii_link_pkg::*;
#(
  parameter int unsigned NIB_W   = NIB_W_DEF,
  parameter int unsigned HDR_NIB = HDR_NIB_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_tx_en,
  input  logic [NIB_W-1:0] a_txd,
  output logic             a_rx_dv,
  output logic [NIB_W-1:0] a_rxd,
  output logic             a_crs,
  output logic             a_col,
  input  logic             b_tx_en,
  input  logic [NIB_W-1:0] b_txd,
  output logic             b_rx_dv,
  output logic [NIB_W-1:0] b_rxd,
  output logic             b_crs,
  output logic             b_col
);
  logic                    rst_n_sync;
  logic [N_ST-1:0]         tx_en_v;
  logic [N_ST-1:0]         hdr_done_v;
  logic [N_ST-1:0]         rx_dv_v;
  logic [NIB_W-1:0]        txd_v [N_ST];
  logic [NIB_W-1:0]        rxd_v [N_ST];
  logic                    crs_q, col_q, lock_q;

  assign tx_en_v[ST_A] = a_tx_en;
  assign tx_en_v[ST_B] = b_tx_en;
  assign txd_v[ST_A]   = a_txd;
  assign txd_v[ST_B]   = b_txd;

  mii_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar s = 0; s < N_ST; s++) begin : g_station
    mii_hdr_counter #(.HDR_NIB(HDR_NIB)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .tx_en    (tx_en_v[s]),
      .hdr_done (hdr_done_v[s])
    );

    mii_rx_steer #(.NIB_W(NIB_W)) u_steer (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .src_en  (tx_en_v[N_ST-1-s]),
      .src_txd (txd_v[N_ST-1-s]),
      .own_en  (tx_en_v[s]),
      .lock    (lock_q),
      .rx_dv   (rx_dv_v[s]),
      .rxd     (rxd_v[s])
    );
  end

  mii_hdx_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .tx_en    (tx_en_v),
    .hdr_done (hdr_done_v),
    .crs      (crs_q),
    .col      (col_q),
    .lock     (lock_q)
  );

  assign a_rx_dv = rx_dv_v[ST_A];
  assign a_rxd   = rxd_v[ST_A];
  assign b_rx_dv = rx_dv_v[ST_B];
  assign b_rxd   = rxd_v[ST_B];
  assign a_crs   = crs_q;
  assign b_crs   = crs_q;
  assign a_col   = col_q;
  assign b_col   = col_q;
endmodule

// File: rtl/mii_hdx_link_chk.sv
module mii_hdx_link_chk #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned HDR_NIB = 44,
  localparam int unsigned LIM    = HDR_NIB + 1,
  localparam int unsigned RUN_W  = $clog2(LIM + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_tx_en,
  input logic [NIB_W-1:0] a_txd,
  input logic             a_rx_dv,
  input logic [NIB_W-1:0] a_rxd,
  input logic             a_crs,
  input logic             a_col,
  input logic             b_tx_en,
  input logic [NIB_W-1:0] b_txd,
  input logic             b_rx_dv,
  input logic [NIB_W-1:0] b_rxd,
  input logic             b_crs,
  input logic             b_col
);
  logic [RUN_W-1:0] run_a, run_b;

  // independent run-length of each transmit enable, saturating at LIM
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_a <= '0;
      run_b <= '0;
    end else begin
      if (!a_tx_en)                   run_a <= '0;
      else if (run_a != RUN_W'(LIM))  run_a <= run_a + RUN_W'(1);
      if (!b_tx_en)                   run_b <= '0;
      else if (run_b != RUN_W'(LIM))  run_b <= run_b + RUN_W'(1);
    end
  end

  // R2
  crs_follows_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_crs == $past(a_tx_en || b_tx_en)) && (b_crs == a_crs));

  // R4
  no_loopback_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_rx_dv |-> !a_tx_en);

  // R4
  no_loopback_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_rx_dv |-> !b_tx_en);

  // R5
  col_late_enough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_col) |-> (run_a == RUN_W'(LIM)) || (run_b == RUN_W'(LIM)));

  // R5
  col_both_sides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_col == b_col);

  // R6
  col_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_col && (a_tx_en || b_tx_en)) |=> a_col);

  // R8
  rxd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_rx_dv |-> a_rxd == '0) and (!b_rx_dv |-> b_rxd == '0));
endmodule

bind mii_hdx_link mii_hdx_link_chk #(.NIB_W(NIB_W), .HDR_NIB(HDR_NIB)) u_chk (.*);

// File: tb/mii_hdx_link_bench.sv
module mii_hdx_link_bench;
  logic       clk;
  logic       rst_n;
  logic       a_tx_en, b_tx_en;
  logic [3:0] a_txd, b_txd;
  logic       a_rx_dv, b_rx_dv, a_crs, b_crs, a_col, b_col;
  logic [3:0] a_rxd, b_rxd;
  int         n_chk;
  int         n_fail;
  bit         done;

  mii_hdx_link u_mii_hdx_link (
    .clk(clk), .rst_n(rst_n),
    .a_tx_en(a_tx_en), .a_txd(a_txd), .a_rx_dv(a_rx_dv), .a_rxd(a_rxd),
    .a_crs(a_crs), .a_col(a_col),
    .b_tx_en(b_tx_en), .b_txd(b_txd), .b_rx_dv(b_rx_dv), .b_rxd(b_rxd),
    .b_crs(b_crs), .b_col(b_col)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic ae, input logic [3:0] ad,
                       input logic be, input logic [3:0] bd);
    a_tx_en = ae; a_txd = ad; b_tx_en = be; b_txd = bd;
  endtask

  task automatic idle(input int n);
    drive(1'b0, 4'h0, 1'b0, 4'h0);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic test_reset();
    drive(1'b0, 4'h0, 1'b0, 4'h0);
    rst_n = 1'b0;
    tick(); tick();
    check("R1 rx_dv/col/crs in reset",
          {a_rx_dv, b_rx_dv, a_col, b_col, a_crs, b_crs}, 0);
    check("R1 rxd in reset", {a_rxd, b_rxd}, 0);
    rst_n = 1'b1;
    idle(4);
    check("R1 outputs after release",
          {a_rx_dv, b_rx_dv, a_col, b_col, a_crs, b_crs}, 0);
  endtask

  task automatic test_a_to_b();
    for (int i = 0; i < 12; i++) begin
      drive(1'b1, 4'(i + 3), 1'b0, 4'h0);
      tick();
      check("R3 b_rx_dv", b_rx_dv, 1);
      check("R3 b_rxd", b_rxd, (i + 3) % 16);
      check("R2 crs both", {a_crs, b_crs}, 3);
      check("R4 a_rx_dv while A talks", a_rx_dv, 0);
    end
    drive(1'b0, 4'h0, 1'b0, 4'h0);
    tick();
    check("R3 b_rx_dv end", b_rx_dv, 0);
    check("R8 b_rxd quiet", b_rxd, 0);
    check("R2 crs end", {a_crs, b_crs}, 0);
    idle(2);
  endtask

  task automatic test_b_to_a();
    for (int i = 0; i < 8; i++) begin
      drive(1'b0, 4'hF, 1'b1, 4'(15 - i));
      tick();
      check("R3 a_rx_dv", a_rx_dv, 1);
      check("R3 a_rxd", a_rxd, 15 - i);
      check("R8 b_rxd quiet", b_rxd, 0);
    end
    idle(2);
  endtask

  task automatic test_turnaround();
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, 4'hA, 1'b0, 4'h0);
      tick();
    end
    check("R3 b_rx_dv before turn", b_rx_dv, 1);
    drive(1'b0, 4'h0, 1'b1, 4'h5);
    #1;
    check("R4 b_rx_dv same cycle", b_rx_dv, 0);
    check("R8 b_rxd same cycle", b_rxd, 0);
    tick();
    check("R3 a_rx_dv after turn", a_rx_dv, 1);
    check("R3 a_rxd after turn", a_rxd, 5);
    idle(2);
  endtask

  task automatic test_collision();
    for (int k = 1; k <= 10; k++) begin
      drive(1'b1, 4'h1, 1'b0, 4'h0);
      tick();
    end
    for (int k = 11; k <= 44; k++) begin
      drive(1'b1, 4'h1, 1'b1, 4'h2);
      tick();
      if (k == 44) check("R5 no col at 44", {a_col, b_col}, 0);
      if (k == 20) check("R7 rx_dv during overlap", {a_rx_dv, b_rx_dv}, 0);
    end
    tick();
    check("R5 col at 45 both sides", {a_col, b_col}, 3);
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 4'h0, 1'b1, 4'h2);
      tick();
      check("R6 col held one active", a_col, 1);
      check("R7 a_rx_dv locked", a_rx_dv, 0);
    end
    drive(1'b0, 4'h0, 1'b0, 4'h0);
    tick();
    check("R6 col clears", {a_col, b_col}, 0);
    idle(2);
  endtask

  task automatic test_short_overlap();
    for (int k = 0; k < 3; k++) begin drive(1'b1, 4'h7, 1'b0, 4'h0); tick(); end
    for (int k = 0; k < 5; k++) begin drive(1'b1, 4'h7, 1'b1, 4'h8); tick(); end
    for (int k = 0; k < 10; k++) begin
      drive(1'b1, 4'h7, 1'b0, 4'h0);
      tick();
      check("R7 b_rx_dv held low", b_rx_dv, 0);
    end
    check("R7 no col on short overlap", a_col, 0);
    idle(1);
    drive(1'b1, 4'h9, 1'b0, 4'h0);
    tick();
    check("R7 b_rx_dv back after idle", b_rx_dv, 1);
    check("R3 b_rxd after unlock", b_rxd, 9);
    idle(2);
  endtask

  task automatic test_late_start();
    for (int k = 0; k < 50; k++) begin drive(1'b1, 4'h3, 1'b0, 4'h0); tick(); end
    check("R9 no col alone", a_col, 0);
    drive(1'b1, 4'h3, 1'b1, 4'h4);
    tick();
    check("R9 col one edge after overlap", {a_col, b_col}, 3);
    idle(2);
    check("R6 col cleared", a_col, 0);
  endtask

  task automatic test_restart();
    for (int k = 0; k < 30; k++) begin drive(1'b1, 4'h6, 1'b0, 4'h0); tick(); end
    idle(1);
    for (int k = 1; k <= 20; k++) begin drive(1'b1, 4'h6, 1'b0, 4'h0); tick(); end
    for (int k = 21; k <= 44; k++) begin
      drive(1'b1, 4'h6, 1'b1, 4'h1);
      tick();
    end
    check("R10 no col before fresh 44", a_col, 0);
    tick();
    check("R10 col after fresh 45", a_col, 1);
    idle(2);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    drive(1'b0, 4'h0, 1'b0, 4'h0);
    test_reset();
    test_a_to_b();
    test_b_to_a();
    test_turnaround();
    test_collision();
    test_short_overlap();
    test_late_start();
    test_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule